// File: doc/BRIEF.md
# Slow-Down Sensor Conditioner for a Motion Axis

This block sits between an external slow-down sensor and the pulse generator of one stepper or servo axis. The sensor pin is synchronised, given a selectable active level, and passed through a stability filter. It can then be masked, and it can be held in a latch. The conditioned level, the current speed phase of the axis and the chosen response mode together produce requests to the pulse generator: ramp down to the low feed speed, or stop.

A start command that arrives while the sensor is active is refused through a start-inhibit output. A stop caused by the sensor leaves a sticky error flag, which stays set until a clear strobe removes it. Two status bits report the synchronised pin level and the latch, both active-high. The ramp generator itself lives outside this block. The speed phase is encoded as 0 stopped, 1 low speed, 2 high speed and 3 decelerating.

Top module: `slowdown_guard`

## Requirements
- R1: With the filter off, a new pin level takes effect on the requests 4 clock edges after the pin changes (2 synchroniser stages plus 2 steady samples). A high pulse of one clock is ignored.
- R2: With the filter on, a new level must be sampled steadily 80 times. A pulse held for 79 clocks is ignored. A level held longer takes effect on the 82nd edge after the change, and release needs the same wait.
- R3: `cfgActiveHigh`=1 makes a high pin active. A value of 0 makes a low pin active.
- R4: `cfgDisable`=1 masks the sensor: no requests are made and the latch does not set, while `statusPin` still reports the pin.
- R5: With `cfgStopMode`=0, an active sensor raises `decelReq` in high speed or decelerating phases and never raises `stopReq`. At low speed the axis keeps feeding with no request.
- R6: With `cfgStopMode`=1, an active sensor raises `stopReq` in the low speed phase and `decelReq` in high or decelerating phases. In the stopped phase neither request is raised. The two requests are never raised together.
- R7: With `cfgLatched`=0, the requests drop once the sensor goes inactive and the filter has accepted the change.
- R8: With `cfgLatched`=1, an accepted active sensor sets `statusLatch` one edge later. The requests then persist after the pin goes inactive, so the axis does not accelerate again.
- R9: The latch clears on the edge of a start strobe given while the filtered sensor is inactive, or on the edge after `cfgLatched` returns to 0.
- R10: `startInhibit` is high in the same cycle as `startStrobe` exactly when the filtered, unmasked sensor is active.
- R11: `errFlag` sets on the edge after `stopReq` is high and stays set until an `errClear` strobe. When a clear and a new set arrive together, the flag stays set.
- R12: `statusPin` gives the pin level after synchronisation and polarity, active-high, 2 edges after a pin change. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdPin | input | 1 | Raw slow-down sensor pin |
| cfgDisable | input | 1 | 1 masks the sensor |
| cfgActiveHigh | input | 1 | Pin polarity, 1 active-high |
| cfgLatched | input | 1 | 1 latched input, 0 level input |
| cfgStopMode | input | 1 | 1 decelerate and stop, 0 decelerate to low feed |
| cfgFilterOn | input | 1 | 1 selects the long stability filter |
| startStrobe | input | 1 | One-cycle start command |
| errClear | input | 1 | One-cycle error-flag clear |
| speedState | input | 2 | Axis phase: 0 stop, 1 low, 2 high, 3 decel |
| decelReq | output | 1 | Request ramp down to low feed speed |
| stopReq | output | 1 | Request immediate stop |
| startInhibit | output | 1 | Start command refused |
| errFlag | output | 1 | Sticky stop-by-sensor error |
| statusPin | output | 1 | Synchronised pin, active-high |
| statusLatch | output | 1 | Sensor latch state |

## Verification
A filter counter that is out of step with the pin shows as `decelReq` moving one or more edges away from the 4th or 82nd edge, so the bench samples on both sides of those edges. A stuck or wrongly cleared latch shows within one clock as `statusLatch` and as requests that remain, or are missing, after the pin is released. A wrong error register shows on the edge after `stopReq`, or on the edge where a clear and a set coincide.

// File: rtl/slowdown_pkg.sv
package slowdown_pkg;

  typedef enum logic [1:0] {
    SPD_STOP  = 2'd0,
    SPD_LOW   = 2'd1,
    SPD_HIGH  = 2'd2,
    SPD_DECEL = 2'd3
  } speed_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchSet;
    logic latchClr;
  } sdCtl_t;

endpackage

// File: rtl/slowdown_datapath.sv
module slowdown_datapath
  import slowdown_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LONG   = 80,
  parameter int FILT_SHORT  = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sdPin,
  input  logic   cfgActiveHigh,
  input  logic   cfgFilterOn,
  input  logic   cfgDisable,
  input  sdCtl_t ctl,
  output logic   sdActive,
  output logic   sdLatch,
  output logic   pinStatus
);

  localparam int CNT_W = $clog2(FILT_LONG + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   polIn;
  logic                   sdFilt;
  logic [CNT_W-1:0]       stableCnt;
  logic [CNT_W-1:0]       needCnt;

  // synchroniser chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sdPin;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdPin};
      end
    end
  endgenerate

  assign polIn     = cfgActiveHigh ? syncQ[SYNC_STAGES-1] : ~syncQ[SYNC_STAGES-1];
  assign pinStatus = polIn;
  assign needCnt   = cfgFilterOn ? CNT_W'(FILT_LONG) : CNT_W'(FILT_SHORT);

  // stability filter: accept a level after needCnt steady samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdFilt    <= 1'b0;
      stableCnt <= '0;
    end else if (polIn == sdFilt) begin
      stableCnt <= '0;
    end else if (stableCnt == needCnt - 1'b1) begin
      sdFilt    <= polIn;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  assign sdActive = sdFilt & ~cfgDisable;

  always_ff @(posedge clk) begin
    if (!rstN)             sdLatch <= 1'b0;
    else if (ctl.latchSet) sdLatch <= 1'b1;
    else if (ctl.latchClr) sdLatch <= 1'b0;
  end

  // filtered level only moves to a value the synchronised input had
  p_filter_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sdFilt != $past(sdFilt)) |-> ($past(polIn) == sdFilt));

  // latch persists unless control issues a clear
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sdLatch && !ctl.latchClr) |=> sdLatch);

endmodule

// File: rtl/slowdown_control.sv
module slowdown_control
  import slowdown_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdActive,
  input  logic       sdLatch,
  input  logic       cfgLatched,
  input  logic       cfgStopMode,
  input  logic       startStrobe,
  input  logic       errClear,
  input  logic [1:0] speedState,
  output sdCtl_t     ctl,
  output logic       decelReq,
  output logic       stopReq,
  output logic       startInhibit,
  output logic       errFlag
);

  speed_e speed;
  logic   sdEff;

  assign speed = speed_e'(speedState);
  assign sdEff = sdActive | (cfgLatched & sdLatch);

  always_comb begin
    ctl.latchSet = cfgLatched & sdActive;
    ctl.latchClr = ~cfgLatched | (startStrobe & ~sdActive);
  end

  always_comb begin
    decelReq = 1'b0;
    stopReq  = 1'b0;
    if (sdEff) begin
      unique case (speed)
        SPD_HIGH, SPD_DECEL: decelReq = 1'b1;
        SPD_LOW:             stopReq  = cfgStopMode;
        default:             ;
      endcase
    end
  end

  assign startInhibit = startStrobe & sdActive;

  always_ff @(posedge clk) begin
    if (!rstN)        errFlag <= 1'b0;
    else if (stopReq) errFlag <= 1'b1;
    else if (errClear) errFlag <= 1'b0;
  end

  p_req_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(stopReq && decelReq));

  p_fl_mode_nostop_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgStopMode |-> !stopReq);

  p_err_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> errFlag);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClear) |=> errFlag);

  p_inhibit_needs_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    startInhibit |-> startStrobe);

endmodule

// File: rtl/slowdown_guard.sv
module slowdown_guard
  import slowdown_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LONG   = 80,
  parameter int FILT_SHORT  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdPin,
  input  logic       cfgDisable,
  input  logic       cfgActiveHigh,
  input  logic       cfgLatched,
  input  logic       cfgStopMode,
  input  logic       cfgFilterOn,
  input  logic       startStrobe,
  input  logic       errClear,
  input  logic [1:0] speedState,
  output logic       decelReq,
  output logic       stopReq,
  output logic       startInhibit,
  output logic       errFlag,
  output logic       statusPin,
  output logic       statusLatch
);

  sdCtl_t ctl;
  logic   sdActive;
  logic   sdLatch;

  slowdown_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LONG  (FILT_LONG),
    .FILT_SHORT (FILT_SHORT)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .sdPin        (sdPin),
    .cfgActiveHigh(cfgActiveHigh),
    .cfgFilterOn  (cfgFilterOn),
    .cfgDisable   (cfgDisable),
    .ctl          (ctl),
    .sdActive     (sdActive),
    .sdLatch      (sdLatch),
    .pinStatus    (statusPin)
  );

  slowdown_control ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .sdActive    (sdActive),
    .sdLatch     (sdLatch),
    .cfgLatched  (cfgLatched),
    .cfgStopMode (cfgStopMode),
    .startStrobe (startStrobe),
    .errClear    (errClear),
    .speedState  (speedState),
    .ctl         (ctl),
    .decelReq    (decelReq),
    .stopReq     (stopReq),
    .startInhibit(startInhibit),
    .errFlag     (errFlag)
  );

  assign statusLatch = sdLatch;

endmodule

// File: tb/slowdown_guard_tb_top.sv
`timescale 1ns/1ps
module slowdown_guard_tb_top;

  logic clk = 1'b0;
  logic rstN, sdPin, cfgDisable, cfgActiveHigh, cfgLatched, cfgStopMode, cfgFilterOn;
  logic startStrobe, errClear;
  logic [1:0] speedState;
  logic decelReq, stopReq, startInhibit, errFlag, statusPin, statusLatch;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  slowdown_guard dut_i (
    .clk(clk), .rstN(rstN), .sdPin(sdPin), .cfgDisable(cfgDisable),
    .cfgActiveHigh(cfgActiveHigh), .cfgLatched(cfgLatched),
    .cfgStopMode(cfgStopMode), .cfgFilterOn(cfgFilterOn),
    .startStrobe(startStrobe), .errClear(errClear), .speedState(speedState),
    .decelReq(decelReq), .stopReq(stopReq), .startInhibit(startInhibit),
    .errFlag(errFlag), .statusPin(statusPin), .statusLatch(statusLatch)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected {decel, stop} from the requirements (R5, R6)
  function automatic logic [1:0] expReq(input bit sdOn, input bit stopMode, input logic [1:0] spd);
    if (!sdOn) return 2'b00;
    case (spd)
      2'd2, 2'd3: return 2'b10;
      2'd1:       return stopMode ? 2'b01 : 2'b00;
      default:    return 2'b00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rstN = 0; sdPin = 0; cfgDisable = 0; cfgActiveHigh = 1; cfgLatched = 0;
    cfgStopMode = 0; cfgFilterOn = 0; startStrobe = 0; errClear = 0; speedState = 2'd0;
    tick(4); rstN = 1; tick(1);
    chk("R12 reset outputs", {decelReq, stopReq, startInhibit, errFlag, statusPin, statusLatch}, 0);

    // R1 / R12 timing with filter off
    speedState = 2'd2;
    sdPin = 1; tick(1);
    chk("R12 status before sync", statusPin, 0);
    tick(1);
    chk("R12 status after 2 edges", statusPin, 1);
    tick(1);
    chk("R1 not yet at edge 3", decelReq, 0);
    tick(1);
    chk("R1 taken at edge 4", decelReq, 1);
    sdPin = 0; tick(6);
    sdPin = 1; tick(1); sdPin = 0; tick(6);
    chk("R1 one-clock pulse ignored", decelReq, 0);

    // R2 long filter
    cfgFilterOn = 1;
    sdPin = 1; tick(79); sdPin = 0; tick(90);
    chk("R2 79-clock pulse ignored", decelReq, 0);
    sdPin = 1; tick(81);
    chk("R2 not yet at edge 81", decelReq, 0);
    tick(1);
    chk("R2 taken at edge 82", decelReq, 1);
    sdPin = 0; tick(81);
    chk("R2 release still held", decelReq, 1);
    tick(1);
    chk("R2 release at edge 82", decelReq, 0);
    cfgFilterOn = 0; tick(4);

    // R3 active-low
    speedState = 2'd0; cfgActiveHigh = 0; sdPin = 1; tick(6);
    speedState = 2'd2; tick(1);
    chk("R3 high pin inactive when active-low", decelReq, 0);
    sdPin = 0; tick(4);
    chk("R3 low pin active when active-low", decelReq, 1);
    speedState = 2'd0; cfgActiveHigh = 1; tick(6);

    // R4 mask
    cfgDisable = 1; cfgLatched = 1; speedState = 2'd2; sdPin = 1; tick(6);
    chk("R4 masked no decel", decelReq, 0);
    chk("R4 status pin still shown", statusPin, 1);
    chk("R4 latch not set", statusLatch, 0);
    speedState = 2'd0; cfgLatched = 0; cfgDisable = 0; sdPin = 0; tick(6);

    // R5 decelerate-to-low-feed mode
    cfgStopMode = 0; sdPin = 1; speedState = 2'd1; tick(6);
    chk("R5 low speed no request", {decelReq, stopReq}, 0);
    speedState = 2'd2; tick(1);
    chk("R5 high speed decel", {decelReq, stopReq}, 2'b10);
    speedState = 2'd3; tick(1);
    chk("R5 decelerating decel", {decelReq, stopReq}, 2'b10);

    // R6 stop mode
    cfgStopMode = 1; speedState = 2'd1; tick(1);
    chk("R6 low speed stop", {decelReq, stopReq}, 2'b01);
    speedState = 2'd2; tick(1);
    chk("R6 high speed decel", {decelReq, stopReq}, 2'b10);
    speedState = 2'd0; tick(1);
    chk("R6 stopped no request", {decelReq, stopReq}, 0);

    // R11 error flag
    chk("R11 flag set by stop", errFlag, 1);
    tick(3);
    chk("R11 flag sticky", errFlag, 1);
    errClear = 1; tick(1); errClear = 0;
    chk("R11 clear", errFlag, 0);
    speedState = 2'd1; errClear = 1; tick(1); errClear = 0; speedState = 2'd0;
    chk("R11 set wins over clear", errFlag, 1);
    errClear = 1; tick(1); errClear = 0;
    chk("R11 clear again", errFlag, 0);

    // R7 level release
    speedState = 2'd2; tick(1);
    chk("R7 active level decel", decelReq, 1);
    sdPin = 0; tick(4);
    chk("R7 level release drops decel", decelReq, 0);

    // R8 latch
    cfgLatched = 1; sdPin = 1; tick(5);
    chk("R8 latch set", statusLatch, 1);
    sdPin = 0; tick(6);
    chk("R8 decel persists after release", decelReq, 1);
    chk("R8 latch persists", statusLatch, 1);
    speedState = 2'd1; tick(1);
    chk("R8 latched stop at low speed", stopReq, 1);

    // R10 / R9 start handling
    speedState = 2'd0; sdPin = 1; tick(6);
    startStrobe = 1; #1;
    chk("R10 start refused while active", startInhibit, 1);
    tick(1); startStrobe = 0;
    chk("R9 start while active keeps latch", statusLatch, 1);
    sdPin = 0; tick(6);
    startStrobe = 1; #1;
    chk("R10 start accepted while inactive", startInhibit, 0);
    tick(1); startStrobe = 0;
    chk("R9 start while inactive clears latch", statusLatch, 0);
    speedState = 2'd2; tick(1);
    chk("R9 no decel after clear", decelReq, 0);
    sdPin = 1; tick(6); sdPin = 0; speedState = 2'd0; tick(6);
    chk("R9 latch re-set", statusLatch, 1);
    cfgLatched = 0; tick(1);
    chk("R9 level select clears latch", statusLatch, 0);
    errClear = 1; tick(1); errClear = 0;

    // random level-mode sweep against expReq
    for (int i = 0; i < 40; i++) begin
      bit want, ah, dis, sm;
      logic [1:0] spd;
      logic [1:0] e;
      want = 1'($urandom); ah = 1'($urandom); dis = 1'($urandom); sm = 1'($urandom);
      spd = 2'($urandom);
      cfgActiveHigh = ah; cfgDisable = dis; cfgStopMode = sm; speedState = spd;
      sdPin = ah ? want : ~want;
      tick(6);
      e = expReq(want & ~dis, sm, spd);
      chk("R5/R6 random requests", {decelReq, stopReq}, e);
      chk("R12 random status pin", statusPin, want);
      chk("R4 random no latch in level", statusLatch, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule